// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Condition Flags

This block is the arithmetic core of an integer datapath. Each cycle it takes two operands and an operation code, forms an adder input pair and an adder carry-in, and registers a result together with four condition flags: negative (N), zero (Z), carry (C) and overflow (V). Subtraction in either operand order is done by adding the bitwise inverse of one operand. Because of this, the carry flag after a subtraction is the adder carry-out, and it means "no borrow". The carry-chaining variants take the stored carry flag as the adder carry-in without change. A subtract-with-carry therefore takes away one extra unit when the stored carry is clear.

Bitwise operations share the output register. They update only N and Z and leave C and V as they were. A flag write enable decides whether an operation's flags are stored at all. The result register loads on every cycle, one clock after the inputs are applied.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation code 4'h0 (add) gives result = a + b (mod 2^32) one clock after the inputs, with adder carry-in 0, and C set to the carry out of bit 31.
- R2: Operation code 4'h2 (subtract) gives a + ~b + 1. C is 1 exactly when a >= b as unsigned numbers, so C=1 means no borrow.
- R3: Operation codes 4'h1 (add with carry) and 4'h3 (subtract with carry) use the stored C flag as the adder carry-in. They give a + b + C and a + ~b + C.
- R4: Operation codes 4'h4 (reverse subtract) and 4'h5 (reverse subtract with carry) swap the operands before inversion. They give b + ~a + 1 and b + ~a + C, and C follows the same no-borrow rule.
- R5: After any operation that updates flags, N equals bit 31 of the registered result.
- R6: After any operation that updates flags, Z is 1 exactly when the whole registered result is zero.
- R7: After an arithmetic operation, V is 1 exactly when the two adder inputs have the same sign and the result has the other sign. This is the same as the carry into bit 31 XOR the carry out of bit 31.
- R8: Operation codes 4'h8 (AND), 4'h9 (OR), 4'hA (XOR) and 4'hB (a AND NOT b) produce the bitwise result. They update N and Z only, and C and V keep their previous values.
- R9: When flag_we is low, all four flags keep their values while the result still updates.
- R10: While rst_n is low, the result and all four flags are 0.
- R11: Operation codes 4'h6, 4'h7 and 4'hC to 4'hF give a result of 0 and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| flag_we | input | 1 | Store this operation's flags when high |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow after subtraction) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The hardest behaviour to reach from the ports is the carry-chaining variants, because their carry-in is a flag that no port can set directly. The stimulus first runs a chosen add or subtract to put C into a known state, 0 or 1. It then runs the add-with-carry, subtract-with-carry or reverse-with-carry operation right after, so both values of the stored carry reach the adder. Runs where C is set and flag_we is then held low, or a bitwise operation follows, check that the stored carry survives and still feeds the next chained operation.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_ADC = 4'h1,
        OP_SUB = 4'h2,
        OP_SBC = 4'h3,
        OP_RSB = 4'h4,
        OP_RSC = 4'h5,
        OP_AND = 4'h8,
        OP_ORR = 4'h9,
        OP_EOR = 4'hA,
        OP_BIC = 4'hB
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_is_arith(input logic [3:0] code);
        return (code <= 4'h5);
    endfunction

    function automatic logic op_is_logic(input logic [3:0] code);
        return (code >= 4'h8) && (code <= 4'hB);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_q,
    output logic [DATA_W-1:0] add_x,
    output logic [DATA_W-1:0] add_y,
    output logic              add_cin,
    output logic              arith_ok
);

    logic swap_ops;
    logic invert_y;
    logic use_carry;

    always_comb begin
        swap_ops  = 1'b0;
        invert_y  = 1'b0;
        use_carry = 1'b0;
        add_cin   = 1'b0;
        arith_ok  = op_is_arith(op);
        unique case (op)
            OP_ADD: begin
                add_cin = 1'b0;
            end
            OP_ADC: begin
                use_carry = 1'b1;
            end
            OP_SUB: begin
                invert_y = 1'b1;
                add_cin  = 1'b1;
            end
            OP_SBC: begin
                invert_y  = 1'b1;
                use_carry = 1'b1;
            end
            OP_RSB: begin
                swap_ops = 1'b1;
                invert_y = 1'b1;
                add_cin  = 1'b1;
            end
            OP_RSC: begin
                swap_ops  = 1'b1;
                invert_y  = 1'b1;
                use_carry = 1'b1;
            end
            default: begin
                add_cin = 1'b0;
            end
        endcase
        if (use_carry) begin
            add_cin = carry_q;
        end
        add_x = swap_ops ? opnd_b : opnd_a;
        add_y = swap_ops ? opnd_a : opnd_b;
        if (invert_y) begin
            add_y = ~add_y;
        end
    end

endmodule

// File: rtl/alu_add_core.sv
module alu_add_core #(
    parameter int DATA_W = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [DATA_W-1:0] add_x,
    input  logic [DATA_W-1:0] add_y,
    input  logic              add_cin,
    output logic [DATA_W-1:0] add_sum,
    output logic              carry_msb_in,
    output logic              carry_out
);

    localparam int LOW_W = DATA_W - 1;

    generate
        if (RIPPLE) begin : g_ripple
            logic [DATA_W:0] chain;
            assign chain[0] = add_cin;
            for (genvar i = 0; i < DATA_W; i++) begin : g_bit
                assign add_sum[i]   = add_x[i] ^ add_y[i] ^ chain[i];
                assign chain[i+1]   = (add_x[i] & add_y[i]) |
                                      ((add_x[i] ^ add_y[i]) & chain[i]);
            end
            assign carry_msb_in = chain[DATA_W-1];
            assign carry_out    = chain[DATA_W];

            // R1
            always_comb begin
                if (!$isunknown({add_x, add_y, add_cin})) begin
                    ripple_sum_chk: assert ({carry_out, add_sum} ==
                        ({1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin}));
                end
            end
        end else begin : g_split
            logic [DATA_W-1:0] low_part;
            logic [1:0]        top_part;
            always_comb begin
                low_part = {1'b0, add_x[LOW_W-1:0]} + {1'b0, add_y[LOW_W-1:0]}
                         + {{LOW_W{1'b0}}, add_cin};
                top_part = {1'b0, add_x[DATA_W-1]} + {1'b0, add_y[DATA_W-1]}
                         + {1'b0, low_part[LOW_W]};
            end
            assign add_sum      = {top_part[0], low_part[LOW_W-1:0]};
            assign carry_msb_in = low_part[LOW_W];
            assign carry_out    = top_part[1];
        end
    endgenerate

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] logic_res,
    output logic              logic_ok
);

    always_comb begin
        logic_ok = op_is_logic(op);
        unique case (op)
            OP_AND:  logic_res = opnd_a & opnd_b;
            OP_ORR:  logic_res = opnd_a | opnd_b;
            OP_EOR:  logic_res = opnd_a ^ opnd_b;
            OP_BIC:  logic_res = opnd_a & ~opnd_b;
            default: logic_res = '0;
        endcase
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit RIPPLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } unit_state_t;

    unit_state_t       state_d, state_q;
    logic [DATA_W-1:0] add_x, add_y, add_sum, logic_res;
    logic              add_cin, carry_msb_in, carry_out;
    logic              arith_ok, logic_ok;

    alu_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_q  (state_q.flg.c),
        .add_x    (add_x),
        .add_y    (add_y),
        .add_cin  (add_cin),
        .arith_ok (arith_ok)
    );

    alu_add_core #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_add (
        .add_x        (add_x),
        .add_y        (add_y),
        .add_cin      (add_cin),
        .add_sum      (add_sum),
        .carry_msb_in (carry_msb_in),
        .carry_out    (carry_out)
    );

    alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .logic_res (logic_res),
        .logic_ok  (logic_ok)
    );

    always_comb begin
        state_d     = state_q;
        state_d.res = '0;
        if (arith_ok) begin
            state_d.res = add_sum;
            if (flag_we) begin
                state_d.flg.n = add_sum[DATA_W-1];
                state_d.flg.z = (add_sum == '0);
                state_d.flg.c = carry_out;
                state_d.flg.v = carry_msb_in ^ carry_out;
            end
        end else if (logic_ok) begin
            state_d.res = logic_res;
            if (flag_we) begin
                state_d.flg.n = logic_res[DATA_W-1];
                state_d.flg.z = (logic_res == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;
    assign flag_n = state_q.flg.n;
    assign flag_z = state_q.flg.z;
    assign flag_c = state_q.flg.c;
    assign flag_v = state_q.flg.v;

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flag_we)) |-> $stable({flag_n, flag_z, flag_c, flag_v}));

    // R5
    n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_we) && $past(arith_ok || logic_ok))
        |-> (flag_n == result[DATA_W-1]));

    // R6
    z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_we) && $past(arith_ok || logic_ok))
        |-> (flag_z == (result == '0)));

    // R8
    logic_cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(logic_ok)) |-> ($stable(flag_c) && $stable(flag_v)));

    // R11
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(arith_ok) && !$past(logic_ok))
        |-> ((result == '0) && $stable({flag_n, flag_z, flag_c, flag_v})));

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_item_t exp_q[$];
    logic [3:0] m_flg = 4'b0000;

    always #2 clk = ~clk;

    alu_flags_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_we(flag_we), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] code, logic [31:0] a, logic [31:0] b, logic we, string tag);
        logic [32:0] s;
        logic [31:0] x, y, r;
        logic        cin, arith, lgc;
        exp_item_t   it;
        @(negedge clk);
        op = code; opnd_a = a; opnd_b = b; flag_we = we;
        arith = (code <= 4'h5);
        lgc   = (code >= 4'h8) && (code <= 4'hB);
        x = (code == 4'h4 || code == 4'h5) ? b : a;
        y = (code == 4'h4 || code == 4'h5) ? a : b;
        if (code >= 4'h2 && code <= 4'h5) y = ~y;
        cin = (code == 4'h2 || code == 4'h4) ? 1'b1 :
              (code == 4'h1 || code == 4'h3 || code == 4'h5) ? m_flg[1] : 1'b0;
        s = {1'b0, x} + {1'b0, y} + {32'd0, cin};
        r = '0;
        if (arith) r = s[31:0];
        else if (code == 4'h8) r = a & b;
        else if (code == 4'h9) r = a | b;
        else if (code == 4'hA) r = a ^ b;
        else if (code == 4'hB) r = a & ~b;
        if (we && arith)
            m_flg = {r[31], r == 0, s[32], (x[31] == y[31]) && (r[31] != x[31])};
        else if (we && lgc)
            m_flg = {r[31], r == 0, m_flg[1:0]};
        it.res = r; it.flg = m_flg; it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, {result, flag_n, flag_z, flag_c, flag_v}, {it.res, it.flg});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {result, flag_n, flag_z, flag_c, flag_v}, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h0, 32'd5, 32'd7, 1, "R1 add");
        drive(4'h0, 32'hFFFF_FFFF, 32'd1, 1, "R1 carry out R6 zero");
        drive(4'h0, 32'h7FFF_FFFF, 32'd1, 1, "R7 add overflow R5");
        drive(4'h2, 32'd9, 32'd9, 1, "R2 equal no borrow");
        drive(4'h2, 32'd1, 32'd2, 1, "R2 borrow R5");
        drive(4'h2, 32'h8000_0000, 32'd1, 1, "R7 sub overflow");
        drive(4'h0, 32'hFFFF_FFFF, 32'd2, 1, "R1 set carry");
        drive(4'h1, 32'd10, 32'd20, 1, "R3 adc carry set");
        drive(4'h1, 32'd10, 32'd20, 1, "R3 adc carry clear");
        drive(4'h3, 32'd50, 32'd8, 1, "R3 sbc carry clear");
        drive(4'h3, 32'd50, 32'd8, 1, "R3 sbc carry set");
        drive(4'h4, 32'd3, 32'd10, 1, "R4 rsb");
        drive(4'h4, 32'd10, 32'd3, 1, "R4 rsb borrow");
        drive(4'h5, 32'd3, 32'd10, 1, "R4 rsc carry clear");
        drive(4'h5, 32'd3, 32'd10, 1, "R4 rsc carry set");
        drive(4'h0, 32'h8000_0000, 32'h8000_0000, 1, "R7 set C and V");
        drive(4'h8, 32'hF0F0_0000, 32'h0F0F_FFFF, 1, "R8 and zero keeps C V");
        drive(4'h9, 32'h8000_0000, 32'h1, 1, "R8 orr negative");
        drive(4'hA, 32'h1234_5678, 32'h1234_5678, 1, "R8 eor");
        drive(4'hB, 32'hFFFF_0000, 32'h0F0F_0F0F, 1, "R8 bic");
        drive(4'h2, 32'd0, 32'd1, 0, "R9 we low keeps flags");
        drive(4'h1, 32'd1, 32'd1, 0, "R9 stored carry feeds adc");
        drive(4'h7, 32'd4, 32'd4, 1, "R11 undefined 7");
        drive(4'hE, 32'd4, 32'd4, 1, "R11 undefined E");
        drive(4'h0, 32'd0, 32'd0, 1, "R6 zero add clears C");
        drive(4'h3, 32'd0, 32'd0, 1, "R3 sbc zero minus one");
        @(negedge clk);
        flag_we = 1'b0;
        op = 4'hF;
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule